// File: doc/BRIEF.md
# Pseudo-Random Pulse-Density DAC

This block produces a one-bit pulse stream that an external resistor-capacitor network averages into an analogue level. A conversion frame has a fixed number of slots, 2^W of them, where W is the width of the level input. The programmed level says exactly how many of those slots carry an asserted output period. Every asserted period lasts exactly one clock. The asserted slots are chosen by a free-running maximal-length LFSR compared against the level. A credit counter holds the pulses still owed in the frame and forces or suppresses pulses near the end of the frame, so the count per frame is always exact. The LFSR runs for 2^W - 1 steps per cycle but a frame has 2^W slots, so its phase moves by one slot each frame. As a result, the same level gives a different pattern in each frame.

In non-return-to-zero (NRZ) operation each slot is one clock, and asserted slots may touch. In return-to-zero (RTZ) operation each slot is two clocks: a data clock, then a forced-low clock. The frame therefore lasts 2^(W+1) clocks, pulses never touch, and even full scale fills at most half the frame. The level and the mode are captured only when a frame starts. A one-clock strobe marks the last clock of every frame.

The control FSM has three states. `ST_IDLE` means stopped with the output low. `ST_DATA` is the data clock of a slot. `ST_GAP` is the forced-low clock of an RTZ slot. The transitions are:
- IDLE→DATA on enable; this is the start of the first frame.
- DATA→DATA in NRZ while enabled; this includes the step into the next frame.
- DATA→GAP in RTZ while enabled.
- GAP→DATA while enabled.
- DATA→IDLE and GAP→IDLE when enable is low; this is an abort.

Top module: `dsdac_pulse_dac`

## Requirements
- R1: After reset, and on every clock after one on which `enable` was sampled low, `dac_out` and `frame_done` are 0.
- R2: In NRZ mode a frame starts on the clock after `enable` is first sampled high and lasts 2^W clocks. `frame_done` is 1 only on the last clock of each frame, and frames follow back to back while `enable` stays high.
- R3: In NRZ mode the number of clocks in a frame on which `dac_out` is 1 equals the captured `high_count`, for every value from 0 to 2^W-1.
- R4: In NRZ mode asserted slots may be adjacent. With `high_count` = 2^W-1 there are 2^W-1 pulses in a frame of 2^W clocks, so at least one pair of consecutive clocks both have `dac_out` = 1.
- R5: In RTZ mode (`rtz_mode` = 1) a frame lasts 2^(W+1) clocks. Counting clock offsets from 0 at frame start, `dac_out` is 0 on every odd offset. `frame_done` is 1 only on the last clock, and the number of pulses equals `high_count`.
- R6: Pulses are scattered rather than grouped. At half scale (`high_count` = 2^(W-1)) an NRZ frame contains more than one separate run of asserted clocks.
- R7: Two consecutive NRZ frames with the same `high_count` produce different pulse patterns.
- R8: `high_count` and `rtz_mode` are captured only at a frame start. Changing them during a frame affects neither that frame's pulse count nor its length.
- R9: Dropping `enable` during a frame aborts it, and the output is idle on the next clock. Raising `enable` again starts a fresh frame of full length with the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the converter; low aborts at the next clock |
| high_count | input | W (16) | Number of asserted slots per frame, captured at frame start |
| rtz_mode | input | 1 | 1 = return-to-zero slots of two clocks, 0 = NRZ; captured at frame start |
| dac_out | output | 1 | Pulse-density output to the RC integrator |
| frame_done | output | 1 | One-clock strobe on the last clock of each frame |

## Verification
Both outputs are decoded combinationally from registers. A value captured at a clock edge is therefore visible during the clock that follows it. The first frame clock is the first full clock after the edge that sampled `enable` high, and `frame_done` falls on exactly clock 2^W-1 (or 2^(W+1)-1 in RTZ) counted from there. The bench drives inputs and samples outputs at the falling edge, half a period away from every capture edge. It changes the next frame's level on the same falling edge as the expected strobe, so that value is captured at the boundary edge. An abort is checked from the first sampled clock after the edge that saw `enable` low.

// File: rtl/dsdac_pkg.sv
`timescale 1ns/1ps
package dsdac_pkg;

    // Control states of the converter
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // stopped, output low
        ST_DATA = 2'd1,   // data clock of a slot
        ST_GAP  = 2'd2    // forced-low clock of an RTZ slot
    } dac_state_e;

    // Right-shift Galois feedback masks giving maximal-length sequences
    function automatic logic [31:0] lfsr_taps(input int unsigned width);
        logic [31:0] m;
        case (width)
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0E08;
            13:      m = 32'h0000_1C80;
            14:      m = 32'h0000_3802;
            15:      m = 32'h0000_6000;
            default: m = 32'h0000_B400;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dsdac_lfsr.sv
`timescale 1ns/1ps
// Free-running maximal-length sequence generator, advanced once per slot.
module dsdac_lfsr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    import dsdac_pkg::*;

    localparam logic [31:0]  TAPS32 = lfsr_taps(W);
    localparam logic [W-1:0] MASK   = TAPS32[W-1:0];
    localparam logic [W-1:0] SEED   = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else if (step) begin
            value <= {1'b0, value[W-1:1]} ^ (value[0] ? MASK : '0);
        end
    end

endmodule

// File: rtl/dsdac_slot_ctr.sv
`timescale 1ns/1ps
// Slot position within the frame, with slots-remaining and last-slot flags.
module dsdac_slot_ctr #(
    parameter int unsigned W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    output logic       last,
    output logic [W:0] left
);
    localparam logic [W:0] SLOTS = {1'b1, {W{1'b0}}};

    logic [W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        last = &idx;
        left = SLOTS - {1'b0, idx};
    end

endmodule

// File: rtl/dsdac_credit.sv
`timescale 1ns/1ps
// Pulses still owed in the frame; decides whether the current slot fires.
module dsdac_credit #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         consume,
    input  logic [W-1:0] lfsr_val,
    input  logic [W-1:0] thresh,
    input  logic [W:0]   slots_left,
    output logic         take,
    output logic [W-1:0] remain
);
    logic must_fire;
    logic want_fire;

    always_comb begin
        must_fire = ({1'b0, remain} >= slots_left);
        want_fire = (lfsr_val < thresh);
        take      = (remain != '0) && (must_fire || want_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (consume && take) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/dsdac_pulse_dac.sv
`timescale 1ns/1ps
// Pseudo-random pulse-density DAC, NRZ or RTZ slots.
module dsdac_pulse_dac #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] high_count,
    input  logic         rtz_mode,
    output logic         dac_out,
    output logic         frame_done
);
    import dsdac_pkg::*;

    dac_state_e   state_q;
    dac_state_e   state_d;
    logic [W-1:0] high_q;
    logic         rtz_q;
    logic         slot_end;
    logic         frame_end;
    logic         load;
    logic         last;
    logic [W:0]   left;
    logic [W-1:0] lfsr_val;
    logic [W-1:0] remain;
    logic         take;
    logic         state_is_idle;

    // Slot and frame boundaries, frame-start capture
    always_comb begin
        state_is_idle = (state_q == ST_IDLE);
        slot_end      = ((state_q == ST_DATA) && !rtz_q) || (state_q == ST_GAP);
        frame_end     = slot_end && last;
        load          = enable && (state_is_idle || frame_end);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = enable ? ST_DATA : ST_IDLE;
            ST_DATA: begin
                if (!enable)    state_d = ST_IDLE;
                else if (rtz_q) state_d = ST_GAP;
                else            state_d = ST_DATA;
            end
            ST_GAP:  state_d = enable ? ST_DATA : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Level and mode captured at frame start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= '0;
            rtz_q  <= 1'b0;
        end else if (load) begin
            high_q <= high_count;
            rtz_q  <= rtz_mode;
        end
    end

    dsdac_slot_ctr #(.W(W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (slot_end),
        .last  (last),
        .left  (left)
    );

    dsdac_lfsr #(.W(W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slot_end),
        .value (lfsr_val)
    );

    dsdac_credit #(.W(W)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (high_count),
        .consume    (slot_end),
        .lfsr_val   (lfsr_val),
        .thresh     (high_q),
        .slots_left (left),
        .take       (take),
        .remain     (remain)
    );

    // Outputs
    always_comb begin
        dac_out    = (state_q == ST_DATA) && take;
        frame_done = frame_end;
    end

endmodule

// File: rtl/dsdac_pulse_dac_chk.sv
`timescale 1ns/1ps
module dsdac_pulse_dac_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         dac_out,
    input logic         frame_done,
    input logic         rtz_q,
    input logic         take,
    input logic [W-1:0] remain,
    input logic [W-1:0] high_q,
    input logic         state_is_idle
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!dac_out && !frame_done));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R3
    credit_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (remain == {{(W-1){1'b0}}, take}));

    // R5
    rtz_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_out && rtz_q) |=> !dac_out);

    // R8
    level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_is_idle && !frame_done && enable) |=> ($stable(high_q) && $stable(rtz_q)));

endmodule

bind dsdac_pulse_dac dsdac_pulse_dac_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .dac_out       (dac_out),
    .frame_done    (frame_done),
    .rtz_q         (rtz_q),
    .take          (take),
    .remain        (remain),
    .high_q        (high_q),
    .state_is_idle (state_is_idle)
);

// File: tb/dsdac_pulse_dac_bench.sv
`timescale 1ns/1ps
module dsdac_pulse_dac_bench;

    localparam int W     = 6;
    localparam int SLOTS = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [W-1:0] high_count = '0;
    logic         rtz_mode = 1'b0;
    logic         dac_out;
    logic         frame_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dsdac_pulse_dac #(.W(W)) u_dsdac_pulse_dac (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .high_count (high_count),
        .rtz_mode   (rtz_mode),
        .dac_out    (dac_out),
        .frame_done (frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one frame from its first clock; sets next level on its last clock.
    task automatic frame_run(input int h, input bit m, input int mid_h,
                             input int nh, input bit nm,
                             output int pulses, output int runs, output int adj,
                             output logic [127:0] pat);
        int n = m ? 2 * SLOTS : SLOTS;
        int len_err = 0;
        int gap_err = 0;
        logic prev = 1'b0;
        pulses = 0; runs = 0; adj = 0; pat = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pat[i] = dac_out;
            if (dac_out) begin
                pulses++;
                if (prev) adj++; else runs++;
            end
            prev = dac_out;
            if (frame_done !== (i == n - 1)) len_err++;
            if (m && (i % 2 == 1) && dac_out) gap_err++;
            if (i == n / 2 && mid_h >= 0) begin
                high_count = W'(mid_h);
                rtz_mode   = ~m;
            end
            if (i == n - 1) begin
                high_count = W'(nh);
                rtz_mode   = nm;
            end
        end
        check(pulses == h, m ? "R5" : "R3", "pulse count", pulses, h);
        check(len_err == 0, m ? "R5" : "R2", "frame strobe position errors", len_err, 0);
        if (m) check(gap_err == 0, "R5", "pulses on odd offsets", gap_err, 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p, r, a;
        logic [127:0] pat_a, pat_b, pat_x;
        int quiet_err;

        // Reset and idle (R1)
        high_count = W'(9);
        repeat (3) @(negedge clk);
        check(dac_out == 1'b0 && frame_done == 1'b0, "R1", "outputs in reset",
              {dac_out, frame_done}, 0);
        rst_n = 1'b1;
        quiet_err = 0;
        repeat (10) begin
            @(negedge clk);
            if (dac_out || frame_done) quiet_err++;
        end
        check(quiet_err == 0, "R1", "activity while disabled", quiet_err, 0);

        // NRZ sweep over every level (R2, R3)
        high_count = '0; rtz_mode = 1'b0; enable = 1'b1;
        for (int h = 0; h < SLOTS; h++) begin
            frame_run(h, 1'b0, -1, (h == SLOTS - 1) ? 0 : h + 1,
                      (h == SLOTS - 1), p, r, a, pat_x);
            if (h == SLOTS - 1)
                check(a > 0, "R4", "adjacent pulse pairs at full scale", a, 1);
        end

        // RTZ sweep over every level (R5)
        for (int h = 0; h < SLOTS; h++) begin
            frame_run(h, 1'b1, -1, (h == SLOTS - 1) ? SLOTS / 2 : h + 1,
                      (h != SLOTS - 1), p, r, a, pat_x);
        end

        // Dispersal and frame-to-frame variation (R6, R7)
        frame_run(SLOTS / 2, 1'b0, -1, SLOTS / 2, 1'b0, p, r, a, pat_a);
        check(r > 1, "R6", "separate pulse runs at half scale", r, 2);
        frame_run(SLOTS / 2, 1'b0, -1, 10, 1'b0, p, r, a, pat_b);
        check(pat_a != pat_b, "R7", "consecutive patterns differ", int'(pat_a == pat_b), 0);

        // Mid-frame level and mode change ignored (R8)
        frame_run(10, 1'b0, 50, 20, 1'b0, p, r, a, pat_x);
        check(p == 10, "R8", "count after mid-frame change", p, 10);

        // Abort mid-frame, then restart (R9, R1)
        for (int i = 0; i < 11; i++) @(negedge clk);
        enable = 1'b0;
        quiet_err = 0;
        for (int i = 0; i < SLOTS + 6; i++) begin
            @(negedge clk);
            if (dac_out || frame_done) quiet_err++;
        end
        check(quiet_err == 0, "R9", "activity after abort", quiet_err, 0);
        high_count = W'(5); rtz_mode = 1'b0; enable = 1'b1;
        frame_run(5, 1'b0, -1, 5, 1'b0, p, r, a, pat_x);
        check(p == 5, "R9", "restart frame count", p, 5);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule